// File: doc/BRIEF.md
# I2C Target Status Flag Tracker

This block follows the events of an I2C bus around the local controller and keeps three status flags up to date: one that records an extension code in the first byte after a start, one that records a hit on the local address, and one that tells whether the local side is in transmit state. It also derives the SDA drive enable from the transmit flag, so that SDA is driven only from the falling edge of the first byte's ninth clock onward, and only while the local side is transmitting.

Start and stop detection, SCL generation, clock stretching and the data shift register are outside this block. They reach it as single-cycle strobes, the shift register contents, the local address and a few software command strobes. A local bit position counter tells the first byte after each start or repeated start from the bytes that follow. In every flag, a clear condition wins over a set condition in the same cycle. All outputs are registered and change one clock after the event that causes the change.

Top module: `i2c_flag_tracker`

## Requirements
- R1: A start strobe resets the bit position to 0 and marks the first byte. Each `scl_rise` advances the position from 1 to 9 and then wraps to 1. The first-byte mark ends on the `scl_fall` that occurs at position 9. Only the first byte can set a flag through the address edge.
- R2: On the 8th `scl_rise` of the first byte, `ext_seen` becomes 1 on the next clock when `rx_byte[7:4]` is 4'b0000 or 4'b1111.
- R3: On the same edge, `own_hit` becomes 1 on the next clock when `rx_byte[7:1]` equals `own_addr`. `rx_byte[0]`, the direction bit, plays no part in the compare.
- R4: `ext_seen` and `own_hit` are cleared on the next clock by `start_det`, `stop_det`, `cmd_release` or `enable` low. Such a clear wins over a set in the same cycle.
- R5: In either role, `tx_mode` is cleared on the next clock by `stop_det`, `cmd_release`, `cmd_wait_cancel`, `enable` low, a 0-to-1 change of `arb_lost`, or by the case where `master_mode` and the next values of both other flags are all 0.
- R6: With `master_mode`=1, `tx_mode` is set by `start_gen`. On the 8th rise of the first byte it is set when `rx_byte[0]`=0 (write) and cleared when `rx_byte[0]`=1 (read).
- R7: With `master_mode`=0, `tx_mode` is cleared by `start_det`. On the 8th rise of the first byte it takes the value of `rx_byte[0]`, so 1 means the remote side reads.
- R8: `sda_oe` is 1 only while `tx_mode` is 1. It turns on one clock after the first byte's 9th `scl_fall`, and it drops on start, on stop, or whenever `tx_mode` drops.
- R9: `cmd_shift_wr` leaves `tx_mode` unchanged. While `tx_mode` is 1, it turns on `sda_oe` on the next clock.
- R10: During and right after synchronous active-low reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Block enable; low holds everything clear |
| start_det | input | 1 | Start or repeated start detected (strobe) |
| stop_det | input | 1 | Stop detected (strobe) |
| scl_rise | input | 1 | SCL rising edge (strobe) |
| scl_fall | input | 1 | SCL falling edge (strobe) |
| rx_byte | input | 8 | Shift register contents, complete at the 8th rise |
| own_addr | input | 7 | Local 7-bit address |
| cmd_release | input | 1 | Software exit from communication (strobe) |
| cmd_wait_cancel | input | 1 | Software wait cancel (strobe) |
| cmd_shift_wr | input | 1 | Software write to the shift register (strobe) |
| master_mode | input | 1 | Local side currently acts as master |
| start_gen | input | 1 | Local master generated a start (strobe) |
| arb_lost | input | 1 | Arbitration-lost indication (level) |
| ext_seen | output | 1 | Extension code received |
| own_hit | output | 1 | Local address matched |
| tx_mode | output | 1 | 1 = transmit state, 0 = receive state |
| sda_oe | output | 1 | SDA drive enable |

## Verification
The assertions check on every cycle the relations that follow directly from the inputs. The flags may rise only after an address edge that carries the right byte. The clear strobes always win. `sda_oe` never stays on without `tx_mode`. A master start and a shift write in transmit state give the stated next state. Only the bench's scenarios show the rest. These are the timing of the drive window relative to the ninth falling edge, that a second byte without a new start cannot set a flag, and the full sweep of address nibbles, direction bits, roles and ending commands. In those scenarios a cycle-by-cycle model and arithmetic expected values are compared against every output.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  // Upper nibble all zeros or all ones marks an extension code.
  function automatic logic is_ext_code(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1 -: 4] == 4'h0) || (b[BYTE_W-1 -: 4] == 4'hF);
  endfunction

  // Seven address bits above the direction bit against the local address.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [ADDR_W-1:0] a);
    return b[BYTE_W-1:1] == a;
  endfunction
endpackage

// File: rtl/i2c_bitpos_track.sv
module i2c_bitpos_track #(
  parameter int FRAME_BITS = 9,
  parameter int ADDR_EDGE  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_det,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic ev_addr_edge,
  output logic ev_frame_fall
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] PRE_EDGE = CNT_W'(ADDR_EDGE - 1);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             first_q, first_d;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] p);
    return (p == LAST_POS) ? CNT_W'(1) : p + CNT_W'(1);
  endfunction

  always_comb begin
    pos_d   = pos_q;
    first_d = first_q;
    if (!enable) begin
      pos_d   = '0;
      first_d = 1'b0;
    end else if (start_det) begin
      pos_d   = '0;
      first_d = 1'b1;
    end else begin
      if (scl_rise) pos_d = bump(pos_q);
      if (scl_fall && pos_q == LAST_POS) first_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      first_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      first_q <= first_d;
    end
  end

  assign ev_addr_edge  = enable && !start_det && scl_rise && first_q && (pos_q == PRE_EDGE);
  assign ev_frame_fall = enable && !start_det && scl_fall && first_q && (pos_q == LAST_POS);
endmodule

// File: rtl/i2c_addr_flags.sv
module i2c_addr_flags
  import i2c_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              cmd_release,
  input  logic              ev_addr_edge,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              ext_d,
  output logic              hit_d,
  output logic              ext_q,
  output logic              hit_q
);
  logic flag_clr;
  assign flag_clr = !enable || start_det || stop_det || cmd_release;

  always_comb begin
    ext_d = ext_q;
    hit_d = hit_q;
    if (flag_clr) begin
      ext_d = 1'b0;
      hit_d = 1'b0;
    end else if (ev_addr_edge) begin
      if (is_ext_code(rx_byte))        ext_d = 1'b1;
      if (addr_hit(rx_byte, own_addr)) hit_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      ext_q <= ext_d;
      hit_q <= hit_d;
    end
  end
endmodule

// File: rtl/i2c_dir_flag.sv
module i2c_dir_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_det,
  input  logic stop_det,
  input  logic cmd_release,
  input  logic cmd_wait_cancel,
  input  logic cmd_shift_wr,
  input  logic arb_rise,
  input  logic master_mode,
  input  logic start_gen,
  input  logic ev_addr_edge,
  input  logic ev_frame_fall,
  input  logic dir_bit,
  input  logic ext_d,
  input  logic hit_d,
  output logic tx_q,
  output logic sda_oe,
  output logic clr_any
);
  logic idle, tx_d, arm_q, arm_d;

  assign idle    = !master_mode && !ext_d && !hit_d;
  assign clr_any = !enable || stop_det || cmd_release || cmd_wait_cancel || arb_rise || idle;

  always_comb begin
    tx_d = tx_q;
    if (clr_any) begin
      tx_d = 1'b0;
    end else if (master_mode) begin
      if (start_gen)         tx_d = 1'b1;
      else if (ev_addr_edge) tx_d = !dir_bit;
    end else begin
      if (start_det)         tx_d = 1'b0;
      else if (ev_addr_edge) tx_d = dir_bit;
    end
  end

  always_comb begin
    arm_d = arm_q;
    if (!tx_d || start_det || stop_det) arm_d = 1'b0;
    else if (ev_frame_fall || cmd_shift_wr) arm_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      arm_q <= arm_d;
    end
  end

  assign sda_oe = tx_q && arm_q;
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
  import i2c_flag_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  parameter int ADDR_EDGE  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              cmd_release,
  input  logic              cmd_wait_cancel,
  input  logic              cmd_shift_wr,
  input  logic              master_mode,
  input  logic              start_gen,
  input  logic              arb_lost,
  output logic              ext_seen,
  output logic              own_hit,
  output logic              tx_mode,
  output logic              sda_oe
);
  logic ev_addr8, ev_ninth_fall, arb_q, arb_rise;
  logic ext_d, hit_d, trc_clr_any;

  always_ff @(posedge clk) begin
    if (!rst_n) arb_q <= 1'b0;
    else        arb_q <= arb_lost;
  end
  assign arb_rise = arb_lost && !arb_q;

  i2c_bitpos_track #(.FRAME_BITS(FRAME_BITS), .ADDR_EDGE(ADDR_EDGE)) u_pos (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_det(start_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_addr_edge(ev_addr8), .ev_frame_fall(ev_ninth_fall)
  );

  i2c_addr_flags u_addr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_det(start_det),
    .stop_det(stop_det), .cmd_release(cmd_release), .ev_addr_edge(ev_addr8),
    .rx_byte(rx_byte), .own_addr(own_addr),
    .ext_d(ext_d), .hit_d(hit_d), .ext_q(ext_seen), .hit_q(own_hit)
  );

  i2c_dir_flag u_dir (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_det(start_det),
    .stop_det(stop_det), .cmd_release(cmd_release),
    .cmd_wait_cancel(cmd_wait_cancel), .cmd_shift_wr(cmd_shift_wr),
    .arb_rise(arb_rise), .master_mode(master_mode), .start_gen(start_gen),
    .ev_addr_edge(ev_addr8), .ev_frame_fall(ev_ninth_fall), .dir_bit(rx_byte[0]),
    .ext_d(ext_d), .hit_d(hit_d),
    .tx_q(tx_mode), .sda_oe(sda_oe), .clr_any(trc_clr_any)
  );
endmodule

// File: rtl/i2c_flag_tracker_chk.sv
module i2c_flag_tracker_chk
  import i2c_flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              start_det,
  input logic              stop_det,
  input logic              cmd_release,
  input logic              cmd_shift_wr,
  input logic              master_mode,
  input logic              start_gen,
  input logic [BYTE_W-1:0] rx_byte,
  input logic [ADDR_W-1:0] own_addr,
  input logic              ev_addr8,
  input logic              trc_clr_any,
  input logic              ext_seen,
  input logic              own_hit,
  input logic              tx_mode,
  input logic              sda_oe
);
  // R2
  ext_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_seen) |-> $past(ev_addr8) && $past(is_ext_code(rx_byte)));

  // R3
  hit_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_hit) |-> $past(ev_addr8) && $past(addr_hit(rx_byte, own_addr)));

  // R4
  addr_flags_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det || cmd_release || !enable) |=> (!ext_seen && !own_hit));

  // R5
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trc_clr_any |=> !tx_mode);

  // R6
  master_start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && start_gen && !trc_clr_any) |=> tx_mode);

  // R7
  slave_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && ev_addr8 && !rx_byte[0]) |=> !tx_mode);

  // R8
  oe_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> tx_mode);

  // R8
  oe_drop_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  // R9
  shift_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_shift_wr && tx_mode && !trc_clr_any && !ev_addr8 && !start_det && !stop_det)
      |=> (tx_mode && sda_oe));
endmodule

bind i2c_flag_tracker i2c_flag_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start_det(start_det),
  .stop_det(stop_det), .cmd_release(cmd_release), .cmd_shift_wr(cmd_shift_wr),
  .master_mode(master_mode), .start_gen(start_gen), .rx_byte(rx_byte),
  .own_addr(own_addr), .ev_addr8(ev_addr8), .trc_clr_any(trc_clr_any),
  .ext_seen(ext_seen), .own_hit(own_hit), .tx_mode(tx_mode), .sda_oe(sda_oe)
);

// File: tb/i2c_flag_tracker_test.sv
module i2c_flag_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, start_det = 1'b0, stop_det = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [6:0] own_addr = 7'h52;
  logic cmd_release = 1'b0, cmd_wait_cancel = 1'b0, cmd_shift_wr = 1'b0;
  logic master_mode = 1'b0, start_gen = 1'b0, arb_lost = 1'b0;
  logic ext_seen, own_hit, tx_mode, sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_flag_tracker uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_det(start_det),
    .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .rx_byte(rx_byte), .own_addr(own_addr), .cmd_release(cmd_release),
    .cmd_wait_cancel(cmd_wait_cancel), .cmd_shift_wr(cmd_shift_wr),
    .master_mode(master_mode), .start_gen(start_gen), .arb_lost(arb_lost),
    .ext_seen(ext_seen), .own_hit(own_hit), .tx_mode(tx_mode), .sda_oe(sda_oe)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle model written from the requirements.
  int  m_pos;
  bit  m_first, m_ext, m_hit, m_tx, m_arm, m_arb;
  always @(posedge clk) begin : model
    bit edge8, fall9, kill, nx_ext, nx_hit, nx_tx, nx_arm, wr;
    if (!rst_n) begin
      m_pos = 0; m_first = 0; m_ext = 0; m_hit = 0; m_tx = 0; m_arm = 0; m_arb = 0;
    end else begin
      edge8 = enable && !start_det && scl_rise && m_first && m_pos == 7;
      fall9 = enable && !start_det && scl_fall && m_first && m_pos == 9;
      kill  = !enable || start_det || stop_det || cmd_release;
      nx_ext = kill ? 1'b0 : (m_ext || (edge8 && (rx_byte[7:4] == 0 || rx_byte[7:4] == 15)));
      nx_hit = kill ? 1'b0 : (m_hit || (edge8 && rx_byte[7:1] == own_addr));
      wr = rx_byte[0];
      nx_tx = m_tx;
      if (master_mode && start_gen) nx_tx = 1;
      else if (master_mode && edge8) nx_tx = ~wr;
      else if (!master_mode && start_det) nx_tx = 0;
      else if (!master_mode && edge8) nx_tx = wr;
      if (!enable || stop_det || cmd_release || cmd_wait_cancel || (arb_lost && !m_arb)
          || (!master_mode && !nx_ext && !nx_hit)) nx_tx = 0;
      nx_arm = m_arm || fall9 || cmd_shift_wr;
      if (!nx_tx || start_det || stop_det) nx_arm = 0;
      if (!enable || start_det) begin
        m_pos = 0; m_first = enable;
      end else begin
        if (scl_rise) m_pos = (m_pos == 9) ? 1 : m_pos + 1;
        if (fall9) m_first = 0;
      end
      m_ext = nx_ext; m_hit = nx_hit; m_tx = nx_tx; m_arm = nx_arm; m_arb = arb_lost;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model ext_seen", ext_seen, m_ext);
      check("R3 model own_hit", own_hit, m_hit);
      check("R5/R6/R7 model tx_mode", tx_mode, m_tx);
      check("R8 model sda_oe", sda_oe, m_tx && m_arm);
    end
  end

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input bit gen);
    @(negedge clk); start_det = 1; start_gen = gen;
    @(negedge clk); start_det = 0; start_gen = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_det = 1;
    @(negedge clk); stop_det = 0;
  endtask

  // Nine SCL periods; optional release strobe on the 8th rising edge.
  task automatic send_byte(input logic [7:0] b, input bit rel8);
    rx_byte = b;
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk); scl_rise = 1; cmd_release = (rel8 && i == 8);
      @(negedge clk); scl_rise = 0; cmd_release = 0;
      @(negedge clk); scl_fall = 1;
      @(negedge clk); scl_fall = 0;
    end
  endtask

  task automatic pulse_cmd(input int which);
    @(negedge clk);
    case (which)
      0: cmd_shift_wr = 1;
      1: cmd_wait_cancel = 1;
      default: cmd_release = 1;
    endcase
    @(negedge clk); cmd_shift_wr = 0; cmd_wait_cancel = 0; cmd_release = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit exp_ext, exp_hit, exp_tx;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ext_seen", ext_seen, 0);
    check("R10 own_hit", own_hit, 0);
    check("R10 tx_mode", tx_mode, 0);
    check("R10 sda_oe", sda_oe, 0);
    rst_n = 1; enable = 1;
    idle_cyc(2);
    check("R10 after reset tx_mode", tx_mode, 0);

    // Sweep: two addresses, all nibbles, both direction bits, both roles.
    for (int a = 0; a < 2; a++) begin
      own_addr = (a == 0) ? 7'h52 : 7'h07;
      for (int nib = 0; nib < 16; nib++) begin
        for (int d = 0; d < 2; d++) begin
          for (int role = 0; role < 2; role++) begin
            int variant;
            variant = (nib + d + role) % 4;
            b = {nib[3:0], own_addr[2:0], d[0]};
            master_mode = role[0];
            do_start(role[0]);
            if (role == 1) begin
              check("R6 start_gen sets tx_mode", tx_mode, 1);
              check("R8 no drive before ninth fall", sda_oe, 0);
            end
            send_byte(b, 0);
            exp_ext = (nib == 0) || (nib == 15);
            exp_hit = (nib[3:0] == own_addr[6:3]);
            exp_tx  = role[0] ? !d[0] : ((exp_ext || exp_hit) ? d[0] : 1'b0);
            check("R2 ext after first byte", ext_seen, exp_ext);
            check("R3 hit after first byte", own_hit, exp_hit);
            check("R6/R7 tx after first byte", tx_mode, exp_tx);
            check("R8 drive after ninth fall", sda_oe, exp_tx);
            case (variant)
              0: begin
                pulse_cmd(0);
                check("R9 shift write keeps tx_mode", tx_mode, exp_tx);
                check("R9 shift write drive", sda_oe, exp_tx);
              end
              1: begin
                pulse_cmd(1);
                check("R5 wait cancel clears tx_mode", tx_mode, 0);
                check("R8 wait cancel drops drive", sda_oe, 0);
              end
              2: begin
                pulse_cmd(2);
                check("R4 release clears ext", ext_seen, 0);
                check("R4 release clears hit", own_hit, 0);
                check("R5 release clears tx_mode", tx_mode, 0);
              end
              default: begin
                if (role == 1) begin
                  @(negedge clk); arb_lost = 1;
                  @(negedge clk);
                  check("R5 arbitration loss clears tx_mode", tx_mode, 0);
                  arb_lost = 0;
                end else begin
                  @(negedge clk); enable = 0;
                  @(negedge clk);
                  check("R4 disable clears ext", ext_seen, 0);
                  check("R4 disable clears hit", own_hit, 0);
                  check("R5 disable clears tx_mode", tx_mode, 0);
                  enable = 1;
                end
              end
            endcase
            do_stop();
            check("R4 stop clears hit", own_hit, 0);
            check("R5 stop clears tx_mode", tx_mode, 0);
            master_mode = 0;
            idle_cyc(1);
          end
        end
      end
    end

    // R1: a later byte without a new start sets nothing.
    own_addr = 7'h52;
    do_start(0);
    send_byte(8'h20, 0);
    send_byte({7'h52, 1'b1}, 0);
    check("R1 second byte no hit", own_hit, 0);
    check("R1 second byte no tx", tx_mode, 0);
    // R1: repeated start marks a new first byte.
    do_start(0);
    send_byte({7'h52, 1'b1}, 0);
    check("R1 repeated start hit", own_hit, 1);
    check("R7 read bit sets tx_mode", tx_mode, 1);
    // R7: start detection clears tx in slave role.
    do_start(0);
    check("R7 start clears tx_mode", tx_mode, 0);
    check("R4 start clears hit", own_hit, 0);
    // R4: release on the 8th rising edge wins over the set.
    send_byte({7'h52, 1'b1}, 1);
    check("R4 clear beats set hit", own_hit, 0);
    check("R4 clear beats set tx", tx_mode, 0);
    do_stop();
    // R3: direction bit ignored by the compare.
    do_start(0);
    send_byte({7'h52, 1'b0}, 0);
    check("R3 write bit still hits", own_hit, 1);
    check("R7 write bit leaves tx_mode 0", tx_mode, 0);
    do_stop();
    idle_cyc(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule